// File: doc/BRIEF.md
# NAND Flash Bus Strobe Sequencer

This block produces the control waveform for a single access on a parallel NAND flash bus. It drives chip enable, write enable, read enable, the command and address latch lines and the data-bus output enable. A host pulses a request and marks the access as data, command or address, and as read or write. The access runs through setup, wait and hold phases, each a programmed number of clock cycles. A separate hi-z count holds off the data-bus drive at the start of a write.

Two timing sets are kept. Data accesses use one. Command and address accesses use the other, which is the attribute set. A data read that directly follows a command or an address access gets an extra latch-to-read-enable gap before its setup phase. When wait stretching is on, the wait phase is extended for as long as the flash ready/busy line is low. The data path can be 8 or 16 bits wide.

Top module: `nand_cycle_seq`

## Requirements
- R1: After reset, all eight timing fields (setup, wait, hold and hi-z of both sets) hold 0x0A, and both latch-to-read delays hold 0xF. Wait stretching is off and the bus is 8 bits wide. In that state nce, nwe and nre are high, and cle, ale, dq_oe, busy and done are low.
- R2: An access is accepted at the clock edge where req is high and the block is idle. Counting from the cycle after that edge, chip enable is low for S+W+H cycles: setup S, then wait W, then hold H. nwe (on a write) or nre (on a read) is low only during the wait cycles.
- R3: Kind codes are 0 = data, 1 = command, 2 = address and 3 = data. Data kinds take the data set (config addresses 0..3 = setup, wait, hold, hi-z). Command and address take the attribute set (addresses 4..7, same field order). cle is high for the whole of a command access and ale for the whole of an address access.
- R4: A setup, wait or hold field programmed to 0 acts as 1 cycle.
- R5: On a write, dq_oe is high from access cycle Z+1 (cycles counted from 0, Z = hi-z field of the active set) until the end of hold, and dq_out carries the write data. On a read, dq_oe stays low.
- R6: A data read that directly follows a command access first spends C+1 cycles with chip enable low and no strobe, where C is config address 8 bits [3:0]. After an address access the gap is A+1 cycles, where A is address 9 bits [3:0]. Writes, and reads that follow a data access, get no gap.
- R7: Config address 10 bit 0 enables wait stretching. While it is set, a wait cycle in which rb is low does not count toward W. While it is clear, rb has no effect.
- R8: Config address 10 bit 1 selects a 16-bit bus. In 8-bit mode, the upper byte of dq_out and of rd_data is zero.
- R9: On a read, rd_data takes dq_in at the clock edge that ends the last wait cycle. It keeps that value until the next read capture.
- R10: done is high for exactly one cycle, the cycle after the last hold cycle. busy is high from the cycle after acceptance through the last hold cycle. A req that arrives while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration field select |
| cfg_wdata | input | 8 | Configuration write value |
| req | input | 1 | Start an access |
| req_kind | input | 2 | 0/3 data, 1 command, 2 address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_data | input | 16 | Write data, command or address value |
| rb | input | 1 | Flash ready/busy, low = busy |
| dq_in | input | 16 | Data bus from the flash |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle end-of-access pulse |
| nce | output | 1 | Chip enable, active low |
| nwe | output | 1 | Write enable, active low |
| nre | output | 1 | Read enable, active low |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| dq_oe | output | 1 | Data-bus drive enable |
| dq_out | output | 16 | Data bus to the flash |
| rd_data | output | 16 | Captured read data |

## Verification
Every strobe, busy and dq_oe change appears in the cycle after the edge that accepts the request, so access cycle 0 is the first cycle after that edge. The gap, setup, wait and hold phases follow back to back. done rises one cycle after the last hold cycle, and rd_data is valid from the first hold cycle. The bench samples all outputs at the falling edge. It drives rb during the wait phase so that the value is seen by the edge that closes that cycle. Its phase and cycle model then steps forward by the same rule the requirements give.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
  localparam int TIME_W = 8;
  localparam logic [TIME_W-1:0] TIME_RST = 8'h0A;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_GAP,
    PH_SETUP,
    PH_WAIT,
    PH_HOLD
  } phase_e;

  localparam logic [1:0] KIND_DATA = 2'd0;
  localparam logic [1:0] KIND_CMD  = 2'd1;
  localparam logic [1:0] KIND_ADDR = 2'd2;

  typedef struct packed {
    logic [TIME_W-1:0] setup;
    logic [TIME_W-1:0] waitc;
    logic [TIME_W-1:0] hold;
    logic [TIME_W-1:0] hiz;
  } tset_t;

  function automatic logic is_data(input logic [1:0] k);
    return (k == KIND_DATA) || (k == 2'd3);
  endfunction

  function automatic logic [TIME_W-1:0] at_least_one(input logic [TIME_W-1:0] v);
    return (v == '0) ? TIME_W'(1) : v;
  endfunction
endpackage

// File: rtl/nand_timing_regs.sv
module nand_timing_regs
  import nand_seq_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DLY_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [TIME_W-1:0] cfg_wdata,
  output tset_t             dset,
  output tset_t             aset,
  output logic [DLY_W-1:0]  cle_gap,
  output logic [DLY_W-1:0]  ale_gap,
  output logic              wait_en,
  output logic              bus16
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dset    <= '{setup: TIME_RST, waitc: TIME_RST, hold: TIME_RST, hiz: TIME_RST};
      aset    <= '{setup: TIME_RST, waitc: TIME_RST, hold: TIME_RST, hiz: TIME_RST};
      cle_gap <= '1;
      ale_gap <= '1;
      wait_en <= 1'b0;
      bus16   <= 1'b0;
    end else if (cfg_we) begin
      case (cfg_addr)
        ADDR_W'(0):  dset.setup <= cfg_wdata;
        ADDR_W'(1):  dset.waitc <= cfg_wdata;
        ADDR_W'(2):  dset.hold  <= cfg_wdata;
        ADDR_W'(3):  dset.hiz   <= cfg_wdata;
        ADDR_W'(4):  aset.setup <= cfg_wdata;
        ADDR_W'(5):  aset.waitc <= cfg_wdata;
        ADDR_W'(6):  aset.hold  <= cfg_wdata;
        ADDR_W'(7):  aset.hiz   <= cfg_wdata;
        ADDR_W'(8):  cle_gap    <= cfg_wdata[DLY_W-1:0];
        ADDR_W'(9):  ale_gap    <= cfg_wdata[DLY_W-1:0];
        ADDR_W'(10): begin
          wait_en <= cfg_wdata[0];
          bus16   <= cfg_wdata[1];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/nand_phase_fsm.sv
module nand_phase_fsm
  import nand_seq_pkg::*;
#(
  parameter int DLY_W  = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic [1:0]        req_kind,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_data,
  input  tset_t             dset,
  input  tset_t             aset,
  input  logic [DLY_W-1:0]  cle_gap,
  input  logic [DLY_W-1:0]  ale_gap,
  input  logic              wait_en,
  input  logic              rb,
  output phase_e            st_nxt,
  output logic [1:0]        kind_nxt,
  output logic              write_nxt,
  output logic [TIME_W:0]   age_nxt,
  output logic [TIME_W-1:0] hiz_nxt,
  output logic [DATA_W-1:0] data_nxt,
  output logic              capture,
  output logic              finish
);
  localparam logic [TIME_W:0] AGE_MAX = '1;

  phase_e            st;
  logic [TIME_W-1:0] cnt, cnt_nxt;
  logic [1:0]        kind_q, last_q, last_nxt;
  logic              write_q;
  logic [TIME_W:0]   age_q;
  logic [DATA_W-1:0] data_q;
  tset_t             cur;

  function automatic tset_t pick(input logic [1:0] k, input tset_t d, input tset_t a);
    return is_data(k) ? d : a;
  endfunction

  always_comb begin
    st_nxt    = st;
    cnt_nxt   = cnt;
    kind_nxt  = kind_q;
    write_nxt = write_q;
    data_nxt  = data_q;
    last_nxt  = last_q;
    capture   = 1'b0;
    finish    = 1'b0;
    age_nxt   = (age_q == AGE_MAX) ? age_q : age_q + 1'b1;
    cur       = pick(kind_q, dset, aset);
    case (st)
      PH_IDLE: begin
        if (req) begin
          kind_nxt  = req_kind;
          write_nxt = req_write;
          data_nxt  = req_data;
          last_nxt  = req_kind;
          age_nxt   = '0;
          if (!req_write && is_data(req_kind) && !is_data(last_q)) begin
            st_nxt  = PH_GAP;
            cnt_nxt = (last_q == KIND_CMD) ? TIME_W'(cle_gap) : TIME_W'(ale_gap);
          end else begin
            st_nxt  = PH_SETUP;
            cnt_nxt = at_least_one(pick(req_kind, dset, aset).setup) - 1'b1;
          end
        end
      end
      PH_GAP: begin
        if (cnt == '0) begin
          st_nxt  = PH_SETUP;
          cnt_nxt = at_least_one(cur.setup) - 1'b1;
        end else cnt_nxt = cnt - 1'b1;
      end
      PH_SETUP: begin
        if (cnt == '0) begin
          st_nxt  = PH_WAIT;
          cnt_nxt = at_least_one(cur.waitc) - 1'b1;
        end else cnt_nxt = cnt - 1'b1;
      end
      PH_WAIT: begin
        if (wait_en && !rb) begin
          cnt_nxt = cnt;
        end else if (cnt == '0) begin
          st_nxt  = PH_HOLD;
          cnt_nxt = at_least_one(cur.hold) - 1'b1;
          capture = !write_q;
        end else cnt_nxt = cnt - 1'b1;
      end
      PH_HOLD: begin
        if (cnt == '0) begin
          st_nxt = PH_IDLE;
          finish = 1'b1;
        end else cnt_nxt = cnt - 1'b1;
      end
      default: st_nxt = PH_IDLE;
    endcase
    hiz_nxt = pick(kind_nxt, dset, aset).hiz;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= PH_IDLE;
      cnt     <= '0;
      kind_q  <= KIND_DATA;
      last_q  <= KIND_DATA;
      write_q <= 1'b0;
      age_q   <= '0;
      data_q  <= '0;
    end else begin
      st      <= st_nxt;
      cnt     <= cnt_nxt;
      kind_q  <= kind_nxt;
      last_q  <= last_nxt;
      write_q <= write_nxt;
      age_q   <= age_nxt;
      data_q  <= data_nxt;
    end
  end

  // R7
  stretch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st == PH_WAIT && wait_en && !rb) |=> (st == PH_WAIT));
  // R10
  accept_chk: assert property (@(posedge clk) disable iff (rst)
    (st == PH_IDLE && req) |=> (st != PH_IDLE));
  // R2
  setup_order_chk: assert property (@(posedge clk) disable iff (rst)
    (st == PH_SETUP) |=> (st == PH_SETUP || st == PH_WAIT));
endmodule

// File: rtl/nand_strobe_gen.sv
module nand_strobe_gen
  import nand_seq_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  phase_e            st_nxt,
  input  logic [1:0]        kind_nxt,
  input  logic              write_nxt,
  input  logic [TIME_W:0]   age_nxt,
  input  logic [TIME_W-1:0] hiz_nxt,
  input  logic [DATA_W-1:0] data_nxt,
  input  logic              capture,
  input  logic              finish,
  input  logic              bus16,
  input  logic [DATA_W-1:0] dq_in,
  output logic              busy,
  output logic              done,
  output logic              nce,
  output logic              nwe,
  output logic              nre,
  output logic              cle,
  output logic              ale,
  output logic              dq_oe,
  output logic [DATA_W-1:0] dq_out,
  output logic [DATA_W-1:0] rd_data
);
  localparam int HALF = DATA_W / 2;

  logic active_n, in_wait;

  function automatic logic [DATA_W-1:0] lane_mask(input logic [DATA_W-1:0] v, input logic wide);
    return wide ? v : {{(DATA_W-HALF){1'b0}}, v[HALF-1:0]};
  endfunction

  always_comb begin
    active_n = (st_nxt != PH_IDLE);
    in_wait  = (st_nxt == PH_WAIT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      nce     <= 1'b1;
      nwe     <= 1'b1;
      nre     <= 1'b1;
      cle     <= 1'b0;
      ale     <= 1'b0;
      dq_oe   <= 1'b0;
      dq_out  <= '0;
      rd_data <= '0;
    end else begin
      busy   <= active_n;
      done   <= finish;
      nce    <= !active_n;
      nwe    <= !(in_wait && write_nxt);
      nre    <= !(in_wait && !write_nxt);
      cle    <= active_n && (kind_nxt == KIND_CMD);
      ale    <= active_n && (kind_nxt == KIND_ADDR);
      dq_oe  <= active_n && write_nxt && (age_nxt > {1'b0, hiz_nxt});
      dq_out <= lane_mask(data_nxt, bus16);
      if (capture) rd_data <= lane_mask(dq_in, bus16);
    end
  end

  // R2
  wr_rd_excl_chk: assert property (@(posedge clk) disable iff (rst) !(!nwe && !nre));
  // R2
  strobe_in_ce_chk: assert property (@(posedge clk) disable iff (rst) (!nwe || !nre) |-> !nce);
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R5
  oe_ce_chk: assert property (@(posedge clk) disable iff (rst) dq_oe |-> (!nce && nre));
  // R3
  latch_excl_chk: assert property (@(posedge clk) disable iff (rst) !(cle && ale));
endmodule

// File: rtl/nand_cycle_seq.sv
module nand_cycle_seq
  import nand_seq_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DLY_W  = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [TIME_W-1:0] cfg_wdata,
  input  logic              req,
  input  logic [1:0]        req_kind,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_data,
  input  logic              rb,
  input  logic [DATA_W-1:0] dq_in,
  output logic              busy,
  output logic              done,
  output logic              nce,
  output logic              nwe,
  output logic              nre,
  output logic              cle,
  output logic              ale,
  output logic              dq_oe,
  output logic [DATA_W-1:0] dq_out,
  output logic [DATA_W-1:0] rd_data
);
  tset_t             dset, aset;
  logic [DLY_W-1:0]  cle_gap, ale_gap;
  logic              wait_en, bus16;
  phase_e            st_nxt;
  logic [1:0]        kind_nxt;
  logic              write_nxt, capture, finish;
  logic [TIME_W:0]   age_nxt;
  logic [TIME_W-1:0] hiz_nxt;
  logic [DATA_W-1:0] data_nxt;

  nand_timing_regs #(.ADDR_W(ADDR_W), .DLY_W(DLY_W)) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .dset(dset), .aset(aset), .cle_gap(cle_gap), .ale_gap(ale_gap),
    .wait_en(wait_en), .bus16(bus16)
  );

  nand_phase_fsm #(.DLY_W(DLY_W), .DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst(rst), .req(req), .req_kind(req_kind), .req_write(req_write),
    .req_data(req_data), .dset(dset), .aset(aset), .cle_gap(cle_gap), .ale_gap(ale_gap),
    .wait_en(wait_en), .rb(rb), .st_nxt(st_nxt), .kind_nxt(kind_nxt),
    .write_nxt(write_nxt), .age_nxt(age_nxt), .hiz_nxt(hiz_nxt), .data_nxt(data_nxt),
    .capture(capture), .finish(finish)
  );

  nand_strobe_gen #(.DATA_W(DATA_W)) u_strobe (
    .clk(clk), .rst(rst), .st_nxt(st_nxt), .kind_nxt(kind_nxt), .write_nxt(write_nxt),
    .age_nxt(age_nxt), .hiz_nxt(hiz_nxt), .data_nxt(data_nxt), .capture(capture),
    .finish(finish), .bus16(bus16), .dq_in(dq_in), .busy(busy), .done(done),
    .nce(nce), .nwe(nwe), .nre(nre), .cle(cle), .ale(ale), .dq_oe(dq_oe),
    .dq_out(dq_out), .rd_data(rd_data)
  );
endmodule

// File: tb/nand_cycle_seq_tb.sv
module nand_cycle_seq_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst, cfg_we, req, req_write, rb;
  logic [3:0]  cfg_addr;
  logic [7:0]  cfg_wdata;
  logic [1:0]  req_kind;
  logic [15:0] req_data, dq_in;
  logic        busy, done, nce, nwe, nre, cle, ale, dq_oe;
  logic [15:0] dq_out, rd_data;

  nand_cycle_seq u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .req(req), .req_kind(req_kind), .req_write(req_write), .req_data(req_data),
    .rb(rb), .dq_in(dq_in), .busy(busy), .done(done), .nce(nce), .nwe(nwe),
    .nre(nre), .cle(cle), .ale(ale), .dq_oe(dq_oe), .dq_out(dq_out), .rd_data(rd_data)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  int dset[4];
  int aset[4];
  int cgap, agap, wen, wide, last_kind;

  localparam logic [7:0] IDLE_V = 8'b1110_0000;

  function automatic int one_min(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic cfg(input int addr, input int val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'(addr); cfg_wdata = 8'(val);
    @(negedge clk);
    cfg_we = 1'b0;
    if (addr < 4) dset[addr] = val;
    else if (addr < 8) aset[addr-4] = val;
    else if (addr == 8) cgap = val & 15;
    else if (addr == 9) agap = val & 15;
    else if (addr == 10) begin wen = val & 1; wide = (val >> 1) & 1; end
  endtask

  // vector order: nce nwe nre cle ale dq_oe busy done
  task automatic access(input string tag, input int kind, input bit wr, input logic [15:0] data,
                        input logic [15:0] din, input int slo, input int sn, input bit poke);
    bit isd;
    int s, w, h, z, d, ph, left, wi, k;
    logic [7:0] ev;
    logic [15:0] exp_bus;
    isd = (kind == 0) || (kind == 3);
    s = one_min(isd ? dset[0] : aset[0]);
    w = one_min(isd ? dset[1] : aset[1]);
    h = one_min(isd ? dset[2] : aset[2]);
    z = isd ? dset[3] : aset[3];
    d = (!wr && isd && (last_kind == 1 || last_kind == 2)) ? ((last_kind == 1 ? cgap : agap) + 1) : 0;
    last_kind = kind;
    @(negedge clk);
    req = 1'b1; req_kind = 2'(kind); req_write = wr; req_data = data; dq_in = din; rb = 1'b1;
    @(negedge clk);
    req = 1'b0;
    ph = (d > 0) ? 1 : 2;
    left = (d > 0) ? d : s;
    wi = 0; k = 0;
    while (ph != 5) begin
      ev = {1'b0, !(ph == 3 && wr), !(ph == 3 && !wr), (kind == 1), (kind == 2),
            (wr && k >= z + 1), 1'b1, 1'b0};
      chk(tag, $sformatf("strobes cycle %0d", k), {24'h0, nce, nwe, nre, cle, ale, dq_oe, busy, done}, {24'h0, ev});
      if (ev[2]) begin
        exp_bus = wide ? data : {8'h00, data[7:0]};
        chk(tag, $sformatf("dq_out cycle %0d", k), {16'h0, dq_out}, {16'h0, exp_bus});
      end
      if (poke && k == 1) begin req = 1'b1; req_kind = 2'd1; end
      else req = 1'b0;
      rb = !(ph == 3 && wi >= slo && wi < slo + sn);
      if (ph == 3) begin
        wi++;
        if (!(wen != 0 && !rb)) left--;
      end else left--;
      if (left == 0) begin
        ph++;
        left = (ph == 2) ? s : (ph == 3) ? w : (ph == 4) ? h : 0;
      end
      k++;
      @(negedge clk);
    end
    rb = 1'b1;
    chk(tag, "end cycle", {24'h0, nce, nwe, nre, cle, ale, dq_oe, busy, done}, {24'h0, IDLE_V | 8'h01});
    if (!wr) begin
      exp_bus = wide ? din : {8'h00, din[7:0]};
      chk(tag, "rd_data", {16'h0, rd_data}, {16'h0, exp_bus});
    end
    if (poke) begin
      for (int i = 0; i < 3; i++) begin
        @(negedge clk);
        chk(tag, "ignored req stays idle", {24'h0, nce, nwe, nre, cle, ale, dq_oe, busy, done}, {24'h0, IDLE_V});
      end
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0; req = 1'b0;
    req_kind = '0; req_write = 1'b0; req_data = '0; rb = 1'b1; dq_in = '0;
    for (int i = 0; i < 4; i++) begin dset[i] = 10; aset[i] = 10; end
    cgap = 15; agap = 15; wen = 0; wide = 0; last_kind = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 idle outputs after reset
    chk("R1", "reset outputs", {24'h0, nce, nwe, nre, cle, ale, dq_oe, busy, done}, {24'h0, IDLE_V});
    // R1 default timing, R2 phase order, R5 hi-z, R8 8-bit lane
    access("R1", 0, 1'b1, 16'hA5C3, 16'h0000, 0, 0, 1'b0);
    access("R2", 0, 1'b0, 16'h0000, 16'h5A7E, 0, 0, 1'b0);
    cfg(0, 2); cfg(1, 3); cfg(2, 1); cfg(3, 1);
    cfg(4, 1); cfg(5, 2); cfg(6, 2); cfg(7, 0);
    cfg(8, 4); cfg(9, 2);
    access("R3", 1, 1'b1, 16'h0070, 16'h0000, 0, 0, 1'b0);
    access("R6", 0, 1'b0, 16'h0000, 16'h00E5, 0, 0, 1'b0);
    access("R3", 2, 1'b1, 16'h0012, 16'h0000, 0, 0, 1'b0);
    access("R6", 3, 1'b0, 16'h0000, 16'h0033, 0, 0, 1'b0);
    access("R6", 0, 1'b0, 16'h0000, 16'h0044, 0, 0, 1'b0);
    access("R5", 3, 1'b1, 16'h00C7, 16'h0000, 0, 0, 1'b0);
    cfg(0, 0); cfg(1, 0); cfg(2, 0);
    access("R4", 0, 1'b1, 16'h0066, 16'h0000, 0, 0, 1'b0);
    access("R4", 0, 1'b0, 16'h0000, 16'h0099, 0, 0, 1'b0);
    cfg(0, 2); cfg(1, 4); cfg(2, 2);
    cfg(10, 1);
    access("R7", 0, 1'b0, 16'h0000, 16'h0081, 1, 3, 1'b0);
    access("R7", 0, 1'b1, 16'h0018, 16'h0000, 0, 2, 1'b0);
    cfg(10, 0);
    access("R7", 0, 1'b0, 16'h0000, 16'h00F0, 0, 5, 1'b0);
    cfg(10, 2);
    access("R8", 0, 1'b1, 16'hBEEF, 16'h0000, 0, 0, 1'b0);
    access("R9", 0, 1'b0, 16'h0000, 16'h1234, 0, 0, 1'b0);
    access("R10", 1, 1'b1, 16'h00FF, 16'h0000, 0, 0, 1'b1);
    // R9 rd_data held after a write access
    chk("R9", "rd_data held", {16'h0, rd_data}, {16'h0, 16'h1234});
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule